// File: doc/BRIEF.md
# Byte-Lane Data Memory with Sized Writes

This block is a word-organised data store reached through a 32-bit byte address. A 2-bit operation code chooses between one read of a full word and three write sizes: byte, halfword or word. Each write touches only the byte lanes that its size and its low address bits select. The lanes not selected keep their contents.

Reads are combinational. They return the whole word whose index comes from the address bits above bit 1. Writes take effect on the rising clock edge. Any alignment a size needs is checked. A halfword or word request that breaks its alignment raises an error flag in that cycle and changes nothing. Sign or zero extension of the returned word is left to the consumer. The number of words is a parameter, and the address bits above the index are not decoded.

Top module: `sized_word_mem`

## Requirements
- R1: While `rst_ni` is low every word is cleared to zero, so an aligned read after reset returns 0x00000000 and `misalign_o` is 0.
- R2: With `en_i` low no word changes at the clock edge, `rdata_o` is 0 and `misalign_o` is 0, whatever the other inputs are.
- R3: Op code 2'b00 with `addr_i[1:0]` = 0 drives `rdata_o` with the stored word in the same cycle, without waiting for a clock edge. The word index is `addr_i[IDX_W+1:2]`, where IDX_W = clog2(DEPTH_WORDS).
- R4: Op code 2'b01 writes `wdata_i[7:0]` into the byte lane that `addr_i[1:0]` selects. The lanes are little-endian: lane k is bits [8k+7:8k]. Any value of `addr_i[1:0]` is allowed, and the other three lanes are unchanged.
- R5: Op code 2'b10 with `addr_i[0]` = 0 writes `wdata_i[15:0]` into bits [15:0] when `addr_i[1]` = 0 and into bits [31:16] when `addr_i[1]` = 1. The other half is unchanged.
- R6: Op code 2'b11 with `addr_i[1:0]` = 0 replaces all 32 bits of the word with `wdata_i`.
- R7: When `en_i` is high, `misalign_o` is 1 in the same cycle if the op is 2'b10 and `addr_i[0]` = 1, or if the op is 2'b00 or 2'b11 and `addr_i[1:0]` ≠ 0. In that case no word changes, and a flagged read returns 0. A byte write never raises the flag.
- R8: Address bits above bit IDX_W+1 are ignored, so two addresses that differ only there refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on its rising edge |
| rst_ni | input | 1 | Active-low reset that clears the array |
| en_i | input | 1 | Access enable |
| op_i | input | 2 | 00 read word, 01 write byte, 10 write halfword, 11 write word |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data, taken from the low bits for narrow writes |
| rdata_o | output | 32 | Word read data, zero unless a valid read is in progress |
| misalign_o | output | 1 | Alignment error for the current request |

## Verification
The read-stability assertion depends on the array changing only through this block's own write port. Two back-to-back aligned reads of one address must therefore see the same word, and the bench never writes between such reads. All properties also assume that the inputs are stable around the rising edge. The bench changes inputs only on the falling edge and samples outputs one time step later. Every misalignment case is driven on its own: a flagged request, then a valid read of the word it targeted.

// File: rtl/sized_word_mem.sv
module sized_word_mem #(
  parameter int DEPTH_WORDS = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [1:0]  op_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        misalign_o
);
  localparam int IDX_W = $clog2(DEPTH_WORDS);
  localparam int LANES = 4;
  localparam logic [1:0] OP_RD = 2'b00;
  localparam logic [1:0] OP_BY = 2'b01;
  localparam logic [1:0] OP_HW = 2'b10;
  localparam logic [1:0] OP_WD = 2'b11;

  logic [31:0] mem [DEPTH_WORDS];
  logic [LANES-1:0] lane_en;
  logic [31:0] lane_dat;
  logic [31:0] merged;

  wire [IDX_W-1:0] idx = addr_i[IDX_W+1:2];
  wire [1:0] lo = addr_i[1:0];
  wire unused_addr_bits = ^addr_i[31:IDX_W+2];

  assign misalign_o = en_i && (((op_i == OP_HW) && lo[0]) ||
                               ((op_i == OP_RD || op_i == OP_WD) && (lo != 2'b00)));

  wire wr_go = en_i && (op_i != OP_RD) && !misalign_o;
  wire rd_go = en_i && (op_i == OP_RD) && !misalign_o;

  assign rdata_o = rd_go ? mem[idx] : '0;

  always_comb begin
    case (op_i)
      OP_BY:   begin lane_en = 4'b0001 << lo;               lane_dat = {4{wdata_i[7:0]}};  end
      OP_HW:   begin lane_en = lo[1] ? 4'b1100 : 4'b0011;   lane_dat = {2{wdata_i[15:0]}}; end
      OP_WD:   begin lane_en = 4'b1111;                     lane_dat = wdata_i;            end
      default: begin lane_en = 4'b0000;                     lane_dat = wdata_i;            end
    endcase
  end

  always_comb begin
    merged = mem[idx];
    for (int l = 0; l < LANES; l++)
      if (lane_en[l]) merged[8*l +: 8] = lane_dat[8*l +: 8];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH_WORDS; w++) mem[w] <= '0;
    end else if (wr_go) begin
      mem[idx] <= merged;
    end
  end
endmodule

module sized_word_mem_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic [1:0]  op_i,
  input logic [31:0] addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        misalign_o
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (rdata_o == 32'h0) && !misalign_o);
  // R7
  byte_never_flagged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> en_i && (op_i != 2'b01));
  // R5
  half_aligned_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 2'b10 && !addr_i[0]) |-> !misalign_o);
  // R6
  word_aligned_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 2'b11 && addr_i[1:0] == 2'b00) |-> !misalign_o);
  // R3
  read_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 2'b00 && addr_i[1:0] == 2'b00 && $past(rst_ni) &&
     $past(en_i) && $past(op_i) == 2'b00 && $past(addr_i) == addr_i)
    |-> rdata_o == $past(rdata_o));
  // R7
  flagged_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misalign_o && op_i == 2'b00) |-> rdata_o == 32'h0);
endmodule

bind sized_word_mem sized_word_mem_chk chk_i (.*);

// File: tb/sized_word_mem_tb.sv
module sized_word_mem_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic misalign_o;
  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  sized_word_mem #(.DEPTH_WORDS(256)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .misalign_o(misalign_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk_i);
    en_i = en; op_i = op; addr_i = a; wdata_i = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    en_i = 1'b0; op_i = 2'b00;
  endtask

  task automatic wr(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
    drive(1'b1, op, a, d);
    @(posedge clk_i);
    idle();
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    drive(1'b1, 2'b00, a, 32'h0);
    chk(req, rdata_o, exp);
    idle();
  endtask

  task automatic t_reset();
    rd_chk("R1 word0", 32'h0, 32'h0);
    rd_chk("R1 last word", 32'h3FC, 32'h0);
    chk("R1 flag", {31'h0, misalign_o}, 32'h0);
  endtask

  task automatic t_word();
    wr(2'b11, 32'h10, 32'hDEADBEEF);
    rd_chk("R6 word write", 32'h10, 32'hDEADBEEF);
    drive(1'b1, 2'b00, 32'h10, 32'h0);
    chk("R3 same-cycle read", rdata_o, 32'hDEADBEEF);
    idle();
  endtask

  task automatic t_byte();
    wr(2'b01, 32'h11, 32'h123456AA);
    rd_chk("R4 lane1", 32'h10, 32'hDEADAAEF);
    wr(2'b01, 32'h13, 32'h00000055);
    rd_chk("R4 lane3", 32'h10, 32'h55ADAAEF);
    wr(2'b01, 32'h10, 32'hFFFFFF01);
    rd_chk("R4 lane0", 32'h10, 32'h55ADAA01);
  endtask

  task automatic t_half();
    wr(2'b11, 32'h20, 32'h0);
    wr(2'b10, 32'h22, 32'hFFFF1234);
    rd_chk("R5 upper half", 32'h20, 32'h12340000);
    wr(2'b10, 32'h20, 32'h9999ABCD);
    rd_chk("R5 lower half", 32'h20, 32'h1234ABCD);
  endtask

  task automatic t_misalign();
    drive(1'b1, 2'b10, 32'h21, 32'hFFFFFFFF);
    chk("R7 half flag", {31'h0, misalign_o}, 32'h1);
    @(posedge clk_i); idle();
    rd_chk("R7 half no write", 32'h20, 32'h1234ABCD);
    drive(1'b1, 2'b11, 32'h22, 32'hFFFFFFFF);
    chk("R7 word flag", {31'h0, misalign_o}, 32'h1);
    @(posedge clk_i); idle();
    rd_chk("R7 word no write", 32'h20, 32'h1234ABCD);
    drive(1'b1, 2'b00, 32'h21, 32'h0);
    chk("R7 read flag", {31'h0, misalign_o}, 32'h1);
    chk("R7 read data zero", rdata_o, 32'h0);
    idle();
    drive(1'b1, 2'b01, 32'h23, 32'h0);
    chk("R7 byte unflagged", {31'h0, misalign_o}, 32'h0);
    @(posedge clk_i); idle();
    rd_chk("R4 byte clears lane3", 32'h20, 32'h0034ABCD);
  endtask

  task automatic t_disable();
    drive(1'b0, 2'b11, 32'h20, 32'hFFFFFFFF);
    chk("R2 data zero", rdata_o, 32'h0);
    chk("R2 flag low", {31'h0, misalign_o}, 32'h0);
    @(posedge clk_i);
    drive(1'b0, 2'b10, 32'h21, 32'hFFFFFFFF);
    chk("R2 misaligned idle flag", {31'h0, misalign_o}, 32'h0);
    @(posedge clk_i); idle();
    rd_chk("R2 no write", 32'h20, 32'h0034ABCD);
  endtask

  task automatic t_alias();
    wr(2'b11, 32'h430, 32'hCAFEF00D);
    rd_chk("R8 alias low", 32'h30, 32'hCAFEF00D);
    rd_chk("R8 alias high", 32'hFFFFFC30, 32'hCAFEF00D);
    rd_chk("R8 neighbour untouched", 32'h34, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_word();
    t_byte();
    t_half();
    t_misalign();
    t_disable();
    t_alias();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule